// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This block sits next to a small 8-bit microcontroller core and decides which interrupt, if any, the core takes. It keeps one pending bit per source. Peripherals set the bits with raise strobes and software clears them with clear strobes. At every instruction boundary the core signals, the unit selects the highest-priority eligible source and tells the core what to do next. The core may be asked to reset itself. It may instead be asked to push its return PC, drop the global interrupt enable and jump to a vector. It may also be told to carry on.

Source 0 is the reset request. It is honoured at any boundary and overrides every other condition. Sources 1 and up are normal interrupts. They are taken only while the global enable is set, and never at the boundary that follows a return-from-interrupt. While the core sleeps, a source competes only if its wake mask overlaps the one-hot sleep-mode code. The vector PC is the source's slot address plus a relocatable table offset, wrapped to the program memory size.

The decisions are single-cycle pulses with no back-pressure. The core must accept `take_irq_o` or `reset_req_o` in the cycle they are high. The boundary strobe is asserted only after the instruction's cycles and the peripheral updates for that step are complete.

Top module: `irq_vector_unit`

## Requirements
- R1: `raise_i[k]` sets pending bit k at the clock edge. `clear_i[k]`, or taking source k, clears it, and a clear beats a raise in the same cycle. Raising a source that is already pending changes nothing, so it is taken exactly once.
- R2: Among the eligible pending normal sources, the lowest index (lowest vector address) wins.
- R3: While `asleep_i` is 1, a source is eligible only if `wake_mask_i[k*SLEEP_W +: SLEEP_W] & sleep_mode_i` is nonzero. A higher-priority source without wake capability is skipped in favour of a lower-priority source that has it.
- R4: While `asleep_i` is 0, every pending source is eligible, whatever its wake mask.
- R5: If bit 0 is pending at a boundary, `reset_req_o` pulses in the next cycle. This happens whatever the values of `gie_i`, `asleep_i` and `reti_done_i`. All pending bits are cleared at that edge, including raises arriving in the same cycle.
- R6: A normal source is taken only when `gie_i` is 1. The take appears as a one-cycle pulse on `take_irq_o` and `clr_gie_o`, with `taken_id_o` set to the source and `return_pc_o` equal to `cur_pc_i` at the boundary.
- R7: `vector_pc_o` = (id * VEC_SPACING + `vec_offset_i`) mod 2^PMEM_AW.
- R8: `push_bytes_o` is 3 when `pc22_i` is 1 and 2 when it is 0.
- R9: At a boundary with `reti_done_i` = 1, no normal source is taken. The request waits and is taken at the next boundary.
- R10: Decisions are made only in cycles with `boundary_i` = 1, using the pending bits as they stood before that edge. Each decision appears one cycle later, and `take_irq_o` and `reset_req_o` are never high together.
- R11: After reset all outputs are 0 and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | N_SRC | Per-source set strobes |
| clear_i | input | N_SRC | Per-source clear strobes |
| boundary_i | input | 1 | Instruction boundary; arbitrate this cycle |
| reti_done_i | input | 1 | Completed instruction was a return-from-interrupt |
| gie_i | input | 1 | Global interrupt enable flag |
| asleep_i | input | 1 | Core is in a sleep state |
| sleep_mode_i | input | SLEEP_W | One-hot current sleep mode |
| wake_mask_i | input | N_SRC*SLEEP_W | Per-source wake masks, SLEEP_W bits each |
| cur_pc_i | input | PC_W | PC to return to |
| vec_offset_i | input | PC_W | Vector table offset in words |
| pc22_i | input | 1 | 1 selects a three-byte return PC |
| take_irq_o | output | 1 | Take-interrupt pulse |
| clr_gie_o | output | 1 | Clear global enable pulse |
| taken_id_o | output | IDW | Index of the source taken |
| vector_pc_o | output | PC_W | New PC |
| return_pc_o | output | PC_W | PC to push |
| push_bytes_o | output | 2 | Bytes to push (2 or 3) |
| reset_req_o | output | 1 | Core reset pulse |

## Verification
The hardest state to reach is a sleeping core holding a higher-priority source that cannot wake it alongside a lower-priority source that can. The stimulus builds this by raising both sources with no boundary strobe, so neither is taken early. It then sets the sleep code and a single wake-mask bit before the boundary. The follow-on boundary after waking must then pick up the skipped source. A return-from-interrupt boundary is also paired with a waiting request, and later with a reset request while the global enable is low. These cases show the holdoff gating normal interrupts but not reset.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_RESET = 2'd1,
    DEC_IRQ   = 2'd2
  } dec_kind_e;

  typedef enum logic [1:0] {
    PUSH_SHORT = 2'd2,
    PUSH_LONG  = 2'd3
  } push_len_e;

  function automatic push_len_e push_len(input logic wide_pc);
    return wide_pc ? PUSH_LONG : PUSH_SHORT;
  endfunction
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raise_i,
  input  logic [N_SRC-1:0] clear_i,
  input  logic [N_SRC-1:0] taken_i,
  input  logic             flush_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (flush_i) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q | raise_i) & ~clear_i & ~taken_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int SLEEP_W = 8,
  localparam int IDW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]         pend_i,
  input  logic [N_SRC*SLEEP_W-1:0] wake_mask_i,
  input  logic [SLEEP_W-1:0]       sleep_mode_i,
  input  logic                     asleep_i,
  input  logic                     gie_i,
  input  logic                     boundary_i,
  input  logic                     reti_i,
  output dec_kind_e                kind_o,
  output logic [IDW-1:0]           win_o
);
  logic [N_SRC-1:0] wake_ok;
  logic [N_SRC-1:0] elig;
  logic             found;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign wake_ok[g] = |(wake_mask_i[g*SLEEP_W +: SLEEP_W] & sleep_mode_i);
    assign elig[g]    = pend_i[g] & (~asleep_i | wake_ok[g]);
  end

  always_comb begin
    found = 1'b0;
    win_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        win_o = IDW'(i);
      end
    end
  end

  always_comb begin
    kind_o = DEC_NONE;
    if (boundary_i) begin
      if (pend_i[0]) begin
        kind_o = DEC_RESET;
      end else if (gie_i && !reti_i && found) begin
        kind_o = DEC_IRQ;
      end
    end
  end
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector #(
  parameter int N_SRC       = 32,
  parameter int PC_W        = 22,
  parameter int PMEM_AW     = 16,
  parameter int VEC_SPACING = 2,
  localparam int IDW        = $clog2(N_SRC)
) (
  input  logic [IDW-1:0]  id_i,
  input  logic [PC_W-1:0] offset_i,
  output logic [PC_W-1:0] vec_pc_o
);
  localparam logic [PC_W-1:0] WRAP_MASK = PC_W'((64'd1 << PMEM_AW) - 64'd1);
  localparam logic [PC_W-1:0] SPACING   = PC_W'(VEC_SPACING);

  logic [PC_W-1:0] slot_addr;
  logic [PC_W-1:0] raw_sum;

  assign slot_addr = PC_W'(id_i) * SPACING;
  assign raw_sum   = slot_addr + offset_i;
  assign vec_pc_o  = raw_sum & WRAP_MASK;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int SLEEP_W     = 8,
  parameter int PC_W        = 22,
  parameter int PMEM_AW     = 16,
  parameter int VEC_SPACING = 2,
  localparam int IDW        = $clog2(N_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         raise_i,
  input  logic [N_SRC-1:0]         clear_i,
  input  logic                     boundary_i,
  input  logic                     reti_done_i,
  input  logic                     gie_i,
  input  logic                     asleep_i,
  input  logic [SLEEP_W-1:0]       sleep_mode_i,
  input  logic [N_SRC*SLEEP_W-1:0] wake_mask_i,
  input  logic [PC_W-1:0]          cur_pc_i,
  input  logic [PC_W-1:0]          vec_offset_i,
  input  logic                     pc22_i,
  output logic                     take_irq_o,
  output logic                     clr_gie_o,
  output logic [IDW-1:0]           taken_id_o,
  output logic [PC_W-1:0]          vector_pc_o,
  output logic [PC_W-1:0]          return_pc_o,
  output logic [1:0]               push_bytes_o,
  output logic                     reset_req_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] taken_vec;
  dec_kind_e        kind;
  logic [IDW-1:0]   win_id;
  logic [PC_W-1:0]  next_vec;

  irqv_pending #(.N_SRC(N_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise_i (raise_i),
    .clear_i (clear_i),
    .taken_i (taken_vec),
    .flush_i (kind == DEC_RESET),
    .pend_o  (pend_q)
  );

  irqv_arbiter #(.N_SRC(N_SRC), .SLEEP_W(SLEEP_W)) u_arb (
    .pend_i       (pend_q),
    .wake_mask_i  (wake_mask_i),
    .sleep_mode_i (sleep_mode_i),
    .asleep_i     (asleep_i),
    .gie_i        (gie_i),
    .boundary_i   (boundary_i),
    .reti_i       (reti_done_i),
    .kind_o       (kind),
    .win_o        (win_id)
  );

  irqv_vector #(
    .N_SRC(N_SRC), .PC_W(PC_W), .PMEM_AW(PMEM_AW), .VEC_SPACING(VEC_SPACING)
  ) u_vec (
    .id_i     (win_id),
    .offset_i (vec_offset_i),
    .vec_pc_o (next_vec)
  );

  always_comb begin
    taken_vec = '0;
    if (kind == DEC_IRQ) taken_vec[win_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_irq_o   <= 1'b0;
      reset_req_o  <= 1'b0;
      taken_id_o   <= '0;
      vector_pc_o  <= '0;
      return_pc_o  <= '0;
      push_bytes_o <= '0;
    end else begin
      take_irq_o  <= (kind == DEC_IRQ);
      reset_req_o <= (kind == DEC_RESET);
      if (kind == DEC_IRQ) begin
        taken_id_o   <= win_id;
        vector_pc_o  <= next_vec;
        return_pc_o  <= cur_pc_i;
        push_bytes_o <= push_len(pc22_i);
      end
    end
  end

  assign clr_gie_o = take_irq_o;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int N_SRC = 32,
  localparam int IDW  = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary_i,
  input logic             gie_i,
  input logic             reti_done_i,
  input logic             pc22_i,
  input logic             take_irq_o,
  input logic             reset_req_o,
  input logic [IDW-1:0]   taken_id_o,
  input logic [1:0]       push_bytes_o,
  input logic [N_SRC-1:0] pend_q
);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq_o && reset_req_o));

  p_take_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> $past(boundary_i && gie_i));

  p_reti_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> !$past(reti_done_i));

  p_reset_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (pend_q == '0));

  p_reset_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(boundary_i));

  p_taken_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> !pend_q[taken_id_o]);

  p_push_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (push_bytes_o == ($past(pc22_i) ? 2'd3 : 2'd2)));
endmodule

bind irq_vector_unit irqv_checker #(.N_SRC(N_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .boundary_i   (boundary_i),
  .gie_i        (gie_i),
  .reti_done_i  (reti_done_i),
  .pc22_i       (pc22_i),
  .take_irq_o   (take_irq_o),
  .reset_req_o  (reset_req_o),
  .taken_id_o   (taken_id_o),
  .push_bytes_o (push_bytes_o),
  .pend_q       (pend_q)
);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  localparam int N  = 32;
  localparam int SW = 8;
  localparam int PW = 22;
  localparam int AW = 16;
  localparam int SP = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    raise_i = '0, clear_i = '0;
  logic            boundary_i = 1'b0, reti_done_i = 1'b0, gie_i = 1'b0;
  logic            asleep_i = 1'b0, pc22_i = 1'b0;
  logic [SW-1:0]   sleep_mode_i = '0;
  logic [N*SW-1:0] wake_mask_i = '0;
  logic [PW-1:0]   cur_pc_i = '0, vec_offset_i = '0;
  logic            take_irq_o, clr_gie_o, reset_req_o;
  logic [4:0]      taken_id_o;
  logic [PW-1:0]   vector_pc_o, return_pc_o;
  logic [1:0]      push_bytes_o;

  irq_vector_unit dut (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  bit m_pend[N];
  bit e_take, e_rst;
  int e_id, e_vec, e_ret, e_push;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      e_take = 0; e_rst = 0;
    end else begin
      int win;
      win = -1;
      e_take = 0; e_rst = 0;
      if (boundary_i) begin
        if (m_pend[0]) e_rst = 1;
        else if (gie_i && !reti_done_i) begin
          for (int i = N - 1; i >= 1; i--)
            if (m_pend[i] && (!asleep_i || ((wake_mask_i[i*SW +: SW] & sleep_mode_i) != 0)))
              win = i;
          if (win >= 0) begin
            e_take = 1; e_id = win;
            e_vec = (win * SP + int'(vec_offset_i)) % (1 << AW);
            e_ret = int'(cur_pc_i);
            e_push = pc22_i ? 3 : 2;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (e_rst) m_pend[i] = 0;
        else m_pend[i] = (m_pend[i] | raise_i[i]) & !clear_i[i] & !(e_take && e_id == i);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(take_irq_o == e_take, "R6 take", take_irq_o, e_take);
    chk(clr_gie_o == e_take, "R6 clr_gie", clr_gie_o, e_take);
    chk(reset_req_o == e_rst, "R5 reset_req", reset_req_o, e_rst);
    if (e_take) begin
      chk(int'(taken_id_o) == e_id, "R2 id", taken_id_o, e_id);
      chk(int'(vector_pc_o) == e_vec, "R7 vector", vector_pc_o, e_vec);
      chk(int'(return_pc_o) == e_ret, "R6 return_pc", return_pc_o, e_ret);
      chk(int'(push_bytes_o) == e_push, "R8 push", push_bytes_o, e_push);
    end
  end

  task automatic raise(input int id);
    raise_i[id] = 1'b1; @(negedge clk); raise_i = '0;
  endtask

  task automatic bnd(input bit reti);
    boundary_i = 1'b1; reti_done_i = reti; @(negedge clk);
    boundary_i = 1'b0; reti_done_i = 1'b0;
  endtask

  task automatic expect_take(input int id, input string tag);
    chk(take_irq_o === 1'b1 && int'(taken_id_o) == id, tag,
        take_irq_o ? int'(taken_id_o) : -1, id);
  endtask

  task automatic expect_none(input string tag);
    chk(take_irq_o === 1'b0 && reset_req_o === 1'b0, tag,
        {take_irq_o, reset_req_o}, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_none("R11 reset outputs");
    chk(vector_pc_o == '0 && push_bytes_o == '0, "R11 reset data", vector_pc_o, 0);

    gie_i = 1; cur_pc_i = 22'h123; vec_offset_i = 22'd64;
    raise(9); raise(5);
    bnd(0); expect_take(5, "R2 lowest index first");
    chk(vector_pc_o == 22'd74, "R7 vector value", vector_pc_o, 74);
    chk(push_bytes_o == 2'd2, "R8 two bytes", push_bytes_o, 2);
    chk(return_pc_o == 22'h123, "R6 return pc", return_pc_o, 'h123);
    bnd(0); expect_take(9, "R2 next source");
    bnd(0); expect_none("R6 nothing left");

    gie_i = 0; raise(3);
    bnd(0); expect_none("R6 gie low blocks");
    gie_i = 1; bnd(0); expect_take(3, "R6 taken once gie set");

    wake_mask_i[7*SW + 2] = 1'b1;
    raise(4); raise(7);
    asleep_i = 1; sleep_mode_i = 8'b0000_0100;
    bnd(0); expect_take(7, "R3 wake-capable chosen in sleep");
    bnd(0); expect_none("R3 non-waker stays held");
    asleep_i = 0; sleep_mode_i = '0;
    bnd(0); expect_take(4, "R4 awake takes any");

    raise(6);
    bnd(1); expect_none("R9 reti holdoff");
    bnd(0); expect_take(6, "R9 taken next boundary");

    raise(11); raise(11);
    bnd(0); expect_take(11, "R1 duplicate raise taken");
    bnd(0); expect_none("R1 duplicate raise once");
    raise(10); clear_i[10] = 1; @(negedge clk); clear_i = '0;
    bnd(0); expect_none("R1 clear drops pending");
    raise_i[12] = 1; clear_i[12] = 1; @(negedge clk); raise_i = '0; clear_i = '0;
    bnd(0); expect_none("R1 clear beats raise");

    raise(8);
    repeat (5) @(negedge clk);
    expect_none("R10 no boundary no decision");
    bnd(0); expect_take(8, "R10 decision at boundary");

    gie_i = 0; raise(13); raise(0);
    raise_i[14] = 1; boundary_i = 1; reti_done_i = 1; @(negedge clk);
    raise_i = '0; boundary_i = 0; reti_done_i = 0;
    chk(reset_req_o === 1'b1 && take_irq_o === 1'b0, "R5 reset ignores gie and reti",
        reset_req_o, 1);
    gie_i = 1;
    bnd(0); expect_none("R5 pending flushed");

    pc22_i = 1; vec_offset_i = 22'd65534; raise(3);
    bnd(0); expect_take(3, "R7 wrap source");
    chk(vector_pc_o == 22'd4, "R7 wrapped vector", vector_pc_o, 4);
    chk(push_bytes_o == 2'd3, "R8 three bytes", push_bytes_o, 3);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule